// File: doc/BRIEF.md
# Split-Screen Scanout Base Selector

This block decides which framebuffer base address a scanout DMA engine reads from. The screen can then show two buffers, one above the other. The host sets three values through a small register write port: a pan offset for the primary buffer, a background-buffer offset, and the line at which the screen splits. The video timing generator supplies two pulses, a raster line event and a vertical-blank event. From these the block issues a one-cycle load strobe with an address. A register inside the block stands in for the DMA engine and captures that address.

At vertical blank the block reloads the primary buffer: the framebuffer base plus the pan offset. At the same point, a split line that the host wrote earlier becomes the active split line. A line event in the middle of the frame switches scanout to the framebuffer base plus the background offset, but only while the active split line is non-zero. The active split line is also driven out so that the timing generator can place its line event. That event is meant to fire one line before the split line, on the first pixel past the active width. When video-capture mode is on, another agent owns buffer control, and the block stays silent.

Top module: `scan_split_base`

## Requirements
- R1: While reset is asserted and after its release, `dma_load_o`, `dma_addr_o`, `dma_base_o` and `split_line_o` are zero. The pan offset, staged background offset, active background offset and pending split line are also zero, and no load occurs until an event arrives.
- R2: A host write with `wr_en_i`=1 decodes `wr_sel_i` as follows:
  - 0 writes the pan offset.
  - 1 writes the staged background offset.
  - 2 writes the pending split line from `wr_data_i[LINE_W-1:0]`.
  - 3 changes nothing.
- R3: A pending split line reaches `split_line_o` only on the clock edge where `vblank_i`=1 and `vcap_en_i`=0. `split_line_o` then holds that value until the next such edge.
- R4: When `vblank_i`=1 and `vcap_en_i`=0 at a clock edge, `dma_load_o` is 1 in the following cycle. In that cycle `dma_addr_o` equals `fb_base_i` plus the pan offset, both taken at that edge.
- R5: When `line_evt_i`=1, `vblank_i`=0, `vcap_en_i`=0 and the active split line is non-zero at a clock edge, `dma_load_o` is 1 in the following cycle. In that cycle `dma_addr_o` equals `fb_base_i` plus the active background offset.
- R6: While the active split line is zero, a line event produces no load.
- R7: When `vblank_i` and `line_evt_i` arrive on the same edge, only the pan-offset load of R4 is issued.
- R8: While `vcap_en_i`=1, no load is issued and the active split line does not change.
- R9: Each qualifying event gives exactly one strobe cycle. `dma_base_o` takes the strobe's address on the edge that ends the strobe, and it holds that value otherwise.
- R10: A pan-offset write made between vertical blanks leaves `dma_base_o` unchanged until the next vertical-blank load.
- R11: The active background offset takes the staged background offset only on a split-line write (select 2). A later select-1 write does not change the address used by line events until the next split-line write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host register write strobe |
| wr_sel_i | input | 2 | Register select (0 pan, 1 background stage, 2 split line, 3 none) |
| wr_data_i | input | ADDR_W | Host write data |
| fb_base_i | input | ADDR_W | Framebuffer base address |
| line_evt_i | input | 1 | Raster line event pulse |
| vblank_i | input | 1 | Vertical blank event pulse |
| vcap_en_i | input | 1 | Video-capture mode, suppresses all reloads |
| dma_load_o | output | 1 | One-cycle base load strobe |
| dma_addr_o | output | ADDR_W | Address carried with the load strobe |
| dma_base_o | output | ADDR_W | Base address captured by the DMA model |
| split_line_o | output | LINE_W | Active split line, for the timing generator |

## Verification
An event or write that is sampled on edge k produces the following results:
- The load strobe and its address appear after edge k.
- The active split line changes at edge k.
- The DMA model's base changes after edge k+1.

The reference model in the bench advances on each rising edge from the same inputs the design sees. Outputs are compared 5 ns after every edge. The directed checks sample one quarter period after the edge that carried the stimulus, or after the next edge for the DMA base, so that each result is read in the cycle it is due.

// File: rtl/scan_sel_pkg.sv
package scan_sel_pkg;
  typedef enum logic [1:0] {
    SEL_PAN   = 2'd0,
    SEL_BG    = 2'd1,
    SEL_SPLIT = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_PAN  = 2'd1,
    SRC_BG   = 2'd2
  } load_src_e;
endpackage

// File: rtl/scan_host_regs.sv
module scan_host_regs
  import scan_sel_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] pan_o,
  output logic [ADDR_W-1:0] bg_o,
  output logic [LINE_W-1:0] pend_o
);
  logic [ADDR_W-1:0] pan_q, bg_stage_q, bg_q;
  logic [LINE_W-1:0] pend_q;
  reg_sel_e sel;

  assign sel = reg_sel_e'(wr_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pan_q      <= '0;
      bg_stage_q <= '0;
      bg_q       <= '0;
      pend_q     <= '0;
    end else if (wr_en_i) begin
      unique case (sel)
        SEL_PAN:   pan_q <= wr_data_i;
        SEL_BG:    bg_stage_q <= wr_data_i;
        SEL_SPLIT: begin
          pend_q <= wr_data_i[LINE_W-1:0];
          bg_q   <= bg_stage_q;   // background offset latched with the split
        end
        default: ;
      endcase
    end
  end

  assign pan_o  = pan_q;
  assign bg_o   = bg_q;
  assign pend_o = pend_q;

  // R2
  unused_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd3) |=> ($stable(pan_q) && $stable(bg_q) && $stable(pend_q)));

  // R11
  bg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_sel_i == 2'd2) |=> $stable(bg_q));
endmodule

// File: rtl/scan_base_seq.sv
module scan_base_seq
  import scan_sel_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] fb_base_i,
  input  logic [ADDR_W-1:0] pan_i,
  input  logic [ADDR_W-1:0] bg_i,
  input  logic [LINE_W-1:0] pend_i,
  input  logic              line_evt_i,
  input  logic              vblank_i,
  input  logic              vcap_en_i,
  output logic              load_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LINE_W-1:0] active_o
);
  load_src_e src;
  logic [ADDR_W-1:0] offs;
  logic              load_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] active_q;

  // vblank wins over the line event
  always_comb begin
    src = SRC_IDLE;
    if (!vcap_en_i) begin
      if (vblank_i)                              src = SRC_PAN;
      else if (line_evt_i && active_q != '0)     src = SRC_BG;
    end
  end

  assign offs = (src == SRC_PAN) ? pan_i : bg_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q   <= 1'b0;
      addr_q   <= '0;
      active_q <= '0;
    end else begin
      load_q <= (src != SRC_IDLE);
      if (src != SRC_IDLE) addr_q <= fb_base_i + offs;
      if (vblank_i && !vcap_en_i) active_q <= pend_i;
    end
  end

  assign load_o   = load_q;
  assign addr_o   = addr_q;
  assign active_o = active_q;

  // R4 R7
  vblank_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vblank_i && !vcap_en_i) |=> (load_o && addr_o == $past(fb_base_i + pan_i)));

  // R5
  split_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_evt_i && !vblank_i && !vcap_en_i && active_o != '0)
      |=> (load_o && addr_o == $past(fb_base_i + bg_i)));

  // R6
  no_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vblank_i && active_o == '0) |=> !load_o);

  // R8
  vcap_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcap_en_i |=> (!load_o && $stable(active_o)));

  // R3
  split_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(active_o) |-> $past(vblank_i && !vcap_en_i));
endmodule

// File: rtl/scan_dma_model.sv
module scan_dma_model #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     base_q <= '0;
    else if (load_i) base_q <= addr_i;
  end

  assign base_o = base_q;

  // R9
  dma_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> base_o == $past(addr_i));

  // R10
  dma_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(base_o));
endmodule

// File: rtl/scan_split_base.sv
module scan_split_base #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] fb_base_i,
  input  logic              line_evt_i,
  input  logic              vblank_i,
  input  logic              vcap_en_i,
  output logic              dma_load_o,
  output logic [ADDR_W-1:0] dma_addr_o,
  output logic [ADDR_W-1:0] dma_base_o,
  output logic [LINE_W-1:0] split_line_o
);
  logic [ADDR_W-1:0] pan, bg;
  logic [LINE_W-1:0] pend;

  scan_host_regs #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .pan_o(pan), .bg_o(bg), .pend_o(pend)
  );

  scan_base_seq #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_seq (
    .clk_i, .rst_ni, .fb_base_i,
    .pan_i(pan), .bg_i(bg), .pend_i(pend),
    .line_evt_i, .vblank_i, .vcap_en_i,
    .load_o(dma_load_o), .addr_o(dma_addr_o), .active_o(split_line_o)
  );

  scan_dma_model #(.ADDR_W(ADDR_W)) u_dma (
    .clk_i, .rst_ni, .load_i(dma_load_o), .addr_i(dma_addr_o), .base_o(dma_base_o)
  );

  // R9
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_load_o |-> $past(vblank_i || line_evt_i));
endmodule

// File: tb/sim_scan_split_base.sv
module sim_scan_split_base;
  localparam int AW = 32;
  localparam int LW = 12;
  localparam logic [AW-1:0] FB = 32'h4000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, le = 1'b0, vb = 1'b0, vc = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [AW-1:0] wd = '0, fb = FB;
  logic dma_load;
  logic [AW-1:0] dma_addr, dma_base;
  logic [LW-1:0] split_line;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  scan_split_base #(.ADDR_W(AW), .LINE_W(LW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_sel_i(sel), .wr_data_i(wd),
    .fb_base_i(fb), .line_evt_i(le), .vblank_i(vb), .vcap_en_i(vc),
    .dma_load_o(dma_load), .dma_addr_o(dma_addr), .dma_base_o(dma_base),
    .split_line_o(split_line)
  );

  // behavioural reference
  logic [AW-1:0] m_pan, m_bgs, m_bg, m_addr, m_dma;
  logic [LW-1:0] m_pend, m_act;
  logic m_load;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pan = '0; m_bgs = '0; m_bg = '0; m_addr = '0; m_dma = '0;
      m_pend = '0; m_act = '0; m_load = 0;
    end else begin
      logic n_load;
      if (m_load) m_dma = m_addr;
      n_load = 0;
      if (!vc) begin
        if (vb) begin n_load = 1; m_addr = fb + m_pan; m_act = m_pend; end
        else if (le && m_act != 0) begin n_load = 1; m_addr = fb + m_bg; end
      end
      m_load = n_load;
      if (we) begin
        if (sel == 2'd0) m_pan = wd;
        else if (sel == 2'd1) m_bgs = wd;
        else if (sel == 2'd2) begin m_pend = wd[LW-1:0]; m_bg = m_bgs; end
      end
    end
  end

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  bit cmp_on = 0;
  always @(posedge clk) begin
    #5;
    if (rst_n && cmp_on) begin
      chk("R9 strobe", AW'(dma_load), AW'(m_load));
      if (m_load) chk("R4 addr", dma_addr, m_addr);
      chk("R9 dma_base", dma_base, m_dma);
      chk("R3 split_line", AW'(split_line), AW'(m_act));
    end
  end

  task automatic cyc(input logic w, input logic [1:0] s, input logic [AW-1:0] d,
                     input logic l, input logic v, input logic c);
    @(negedge clk);
    we = w; sel = s; wd = d; le = l; vb = v; vc = c;
    @(posedge clk); #5;
  endtask

  task automatic idle(); cyc(0, 2'd0, '0, 0, 0, 0); endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end

  initial begin
    #35;
    chk("R1 load", AW'(dma_load), 0);
    chk("R1 base", dma_base, 0);
    chk("R1 split", AW'(split_line), 0);
    @(negedge clk); rst_n = 1;
    idle();
    chk("R1 after release load", AW'(dma_load), 0);
    chk("R1 after release addr", dma_addr, 0);
    cmp_on = 1;

    cyc(1, 2'd0, 32'h100, 0, 0, 0);           // pan
    cyc(1, 2'd1, 32'h8000, 0, 0, 0);          // bg stage
    cyc(1, 2'd2, 32'd40, 0, 0, 0);            // pending split
    chk("R3 pending not yet active", AW'(split_line), 0);
    cyc(0, 2'd0, '0, 1, 0, 0);
    chk("R6 line event with split zero", AW'(dma_load), 0);
    cyc(0, 2'd0, '0, 0, 1, 0);
    chk("R4 vblank strobe", AW'(dma_load), 1);
    chk("R4 vblank addr", dma_addr, FB + 32'h100);
    chk("R3 split committed", AW'(split_line), 40);
    idle();
    chk("R9 strobe one cycle", AW'(dma_load), 0);
    chk("R9 base captured", dma_base, FB + 32'h100);

    cyc(1, 2'd1, 32'h9000, 0, 0, 0);          // restage, no split write
    cyc(0, 2'd0, '0, 1, 0, 0);
    chk("R5 split strobe", AW'(dma_load), 1);
    chk("R11 bg kept from split write", dma_addr, FB + 32'h8000);
    idle();
    chk("R5 base to bg", dma_base, FB + 32'h8000);

    cyc(1, 2'd0, 32'h200, 0, 0, 0);           // mid-frame pan
    idle(); idle();
    chk("R10 pan write holds base", dma_base, FB + 32'h8000);
    cyc(1, 2'd3, 32'hDEAD, 0, 0, 0);          // ignored select
    cyc(0, 2'd0, '0, 0, 1, 0);
    chk("R2 sel3 ignored, pan used", dma_addr, FB + 32'h200);
    idle();
    chk("R10 base after vblank", dma_base, FB + 32'h200);

    cyc(1, 2'd2, 32'd80, 0, 0, 0);            // split write captures 0x9000
    cyc(0, 2'd0, '0, 1, 1, 0);
    chk("R7 both events: pan addr", dma_addr, FB + 32'h200);
    chk("R3 split 80 committed", AW'(split_line), 80);
    idle();
    chk("R7 single strobe", AW'(dma_load), 0);
    cyc(0, 2'd0, '0, 1, 0, 0);
    chk("R11 new bg after split write", dma_addr, FB + 32'h9000);

    cyc(1, 2'd2, 32'd0, 0, 0, 1);
    cyc(0, 2'd0, '0, 1, 1, 1);
    chk("R8 vcap no strobe", AW'(dma_load), 0);
    chk("R8 vcap split held", AW'(split_line), 80);
    idle();
    chk("R8 vcap base held", dma_base, FB + 32'h9000);
    cyc(0, 2'd0, '0, 0, 1, 0);
    chk("R3 zero split committed", AW'(split_line), 0);
    cyc(0, 2'd0, '0, 1, 0, 0);
    chk("R6 no strobe after split cleared", AW'(dma_load), 0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[1:0] == 0, r[3:2], (r[3:2] == 2'd2) ? 32'(r[9:4]) : $urandom,
          r[12:10] == 0, r[16:13] == 0, r[21:18] == 0);
      if (i == 1500) fb = 32'h2000_0000;
    end

    idle(); idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule